// File: doc/BRIEF.md
# Transmit Modulation Source Selector

This block picks the bit stream that drives a transmit modulator. It has four sources. The first is a bit taken straight from a general-purpose pin. The second is a bit taken from the serial data input pin, used only while the active-low chip select is deasserted. The third is a byte FIFO that the block shifts out one bit at a time. The fourth is an internal nine-stage pseudo-random generator.

An 8-bit control register sets the source. It also holds an invert bit and a two-bit routing field. The routing field sends a transmit data clock to one of three pins: the general-purpose pin, the serial data output pin, or the interrupt pin. The frequency-deviation MSB and the modulation-type bits pass through to the modulator.

Transmission runs while `tx_en` is high. An external bit-rate strobe marks each bit boundary. The data clock is made from the measured strobe interval, so that its rising edge falls halfway through each bit. When a new source is written, the switch waits for the next bit boundary.

Top module: `txmod_src_sel`

## Requirements
- R1: After reset the control register reads 0x23. This gives FIFO source, no data clock, no inversion, frequency-deviation MSB 0 and modulation type 3.
- R2: A write to the control register takes effect at the next clock edge. The field layout, from bit 7 down to bit 0, is: clock route [7:6], source [5:4], invert [3], frequency-deviation MSB [2], modulation type [1:0].
- R3: Source 00 passes `gpio_in` to `mod_data` combinationally, in the same cycle, with no storage.
- R4: Source 01 passes `sdi_in` combinationally while `csn_in` is 1. While `csn_in` is 0 the raw source bit is held at 0, and it is still subject to inversion.
- R5: Source 10 shifts out FIFO bytes MSB first, one bit per boundary. The block pulses `fifo_pop` for one cycle, and takes `fifo_data` at that edge, in two cases: at transmit start, and at the boundary after the last bit of a byte.
- R6: Source 11 outputs a sequence that is seeded to all ones at its first bit. Bit n+9 equals bit n XOR bit n+5. The sequence advances once per boundary.
- R7: When the invert bit is 1, `mod_data` is the complement of the selected source bit.
- R8: A change of the source field takes effect only at a boundary, which is a transmit start or a `bit_stb` edge while transmitting. A newly selected FIFO or sequence source starts fresh at that boundary.
- R9: Clock route 01 drives `gpio_clk_o`, 11 drives `irq_clk_o`, and 10 drives `sdo_clk_o` only while `csn_in` is 1. Pins that are not selected output 0. The route takes effect at once.
- R10: The data clock is low for the first half of each bit and high from cycle floor(P/2) after the boundary, where P is the previous bit's length in cycles. In the first bit after a transmit start the clock stays low.
- R11: While `tx_en` is 0, `mod_data` and all three clock pins are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| tx_en | input | 1 | Transmit active |
| bit_stb | input | 1 | Bit-rate strobe, one cycle per bit |
| gpio_in | input | 1 | Direct data from the general-purpose pin |
| sdi_in | input | 1 | Direct data from the serial data input pin |
| csn_in | input | 1 | Active-low chip select |
| fifo_data | input | BYTE_W | Head byte of the FIFO |
| fifo_pop | output | 1 | Consume the head byte at this edge |
| mod_data | output | 1 | Data bit to the modulator |
| mod_type | output | 2 | Modulation type field |
| fdev_msb | output | 1 | Frequency-deviation MSB |
| gpio_clk_o | output | 1 | Data clock drive on the general-purpose pin |
| sdo_clk_o | output | 1 | Data clock drive on the serial data output pin |
| irq_clk_o | output | 1 | Data clock drive on the interrupt pin |

## Verification
Each result has its own timing:
- Direct-pin data, inversion, the chip-select hold and clock routing are combinational. The bench changes the input and samples 1 ns later in the same cycle.
- FIFO bits, sequence bits and source switches appear one edge after the boundary. The bench drives the strobe or `tx_en` on a falling edge and samples on the next falling edge.
- The data clock is checked cycle by cycle after a boundary. The bench counts falling edges and expects the pin to go high once floor(P/2) of them have passed.

// File: rtl/txmod_pkg.sv
package txmod_pkg;

  typedef enum logic [1:0] {
    SRC_GPIO = 2'b00,
    SRC_SDI  = 2'b01,
    SRC_FIFO = 2'b10,
    SRC_PN9  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'b00,
    CK_GPIO = 2'b01,
    CK_SDO  = 2'b10,
    CK_IRQ  = 2'b11
  } ckrt_e;

  typedef struct packed {
    ckrt_e      ck;
    src_e       src;
    logic       inv;
    logic       fdev_msb;
    logic [1:0] mtype;
  } ctl_t;

  localparam logic [7:0] CTL_RST = 8'h23;

endpackage

// File: rtl/txmod_ctlreg.sv
module txmod_ctlreg
  import txmod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctl_t       ctl_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_o <= ctl_t'(CTL_RST);
    else if (we) ctl_o <= ctl_t'(wdata);
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctl_o == ctl_t'($past(wdata)))); // R2

endmodule

// File: rtl/txmod_fifo_ser.sv
module txmod_fifo_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              bit_o,
  output logic              empty_o
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      cnt_q <= CNT_W'(BYTE_W - 1);
    end else if (shift) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[BYTE_W-1];
  assign empty_o = (cnt_q == '0);

  AST_FIFO_NO_SHIFT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !empty_o); // R5
  AST_FIFO_NO_DOUBLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R5

endmodule

// File: rtl/txmod_pn9.sv
module txmod_pn9 #(
  parameter int PN_W   = 9,
  parameter int PN_TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic adv,
  output logic bit_o
);

  logic [PN_W-1:0] st_q;

  function automatic logic [PN_W-1:0] pn_step(input logic [PN_W-1:0] s);
    return {s[0] ^ s[PN_TAP], s[PN_W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '1;
    else if (seed) st_q <= '1;
    else if (adv)  st_q <= pn_step(st_q);
  end

  assign bit_o = st_q[0];

  AST_PN_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R6

endmodule

// File: rtl/txmod_bitclk.sv
module txmod_bitclk #(
  parameter int PER_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  input  logic bnd_run,
  output logic clk_o
);

  logic [PER_W-1:0] ph_q;
  logic [PER_W-1:0] per_q;

  function automatic logic [PER_W-1:0] half_of(input logic [PER_W-1:0] p);
    return p >> 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      per_q <= '0;
    end else if (start) begin
      ph_q  <= '0;
      per_q <= '0;
    end else if (bnd_run) begin
      per_q <= ph_q + 1'b1;
      ph_q  <= '0;
    end else if (run && (ph_q != '1)) begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  assign clk_o = run && (per_q != '0) && (ph_q >= half_of(per_q));

  AST_CLK_LOW_AFTER_BND: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_run && (ph_q != '0)) |=> !clk_o); // R10
  AST_CLK_LOW_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !clk_o); // R10

endmodule

// File: rtl/txmod_src_sel.sv
module txmod_src_sel
  import txmod_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int BYTE_W = 8,
  parameter int PN_W   = 9,
  parameter int PN_TAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              tx_en,
  input  logic              bit_stb,
  input  logic              gpio_in,
  input  logic              sdi_in,
  input  logic              csn_in,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              mod_data,
  output logic [1:0]        mod_type,
  output logic              fdev_msb,
  output logic              gpio_clk_o,
  output logic              sdo_clk_o,
  output logic              irq_clk_o
);

  ctl_t ctl;
  logic tx_q;
  src_e src_act;

  // named events for checking
  logic start, bnd_run, bnd;
  logic fifo_load, fifo_shift, fifo_bit, fifo_empty;
  logic pn_seed, pn_adv, pn_bit;
  logic ck_raw, sel_bit;

  txmod_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctl_o(ctl)
  );

  assign start   = tx_en & ~tx_q;
  assign bnd_run = tx_en & tx_q & bit_stb;
  assign bnd     = start | bnd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      src_act <= SRC_FIFO;
    end else begin
      tx_q <= tx_en;
      if (bnd) src_act <= ctl.src;
    end
  end

  assign fifo_load  = bnd && (ctl.src == SRC_FIFO) &&
                      (start || (src_act != SRC_FIFO) || fifo_empty);
  assign fifo_shift = bnd_run && (ctl.src == SRC_FIFO) &&
                      (src_act == SRC_FIFO) && !fifo_empty;
  assign fifo_pop   = fifo_load;

  txmod_fifo_ser #(.BYTE_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .load(fifo_load), .shift(fifo_shift),
    .din(fifo_data), .bit_o(fifo_bit), .empty_o(fifo_empty)
  );

  assign pn_seed = bnd && (ctl.src == SRC_PN9) && (start || (src_act != SRC_PN9));
  assign pn_adv  = bnd_run && (ctl.src == SRC_PN9) && (src_act == SRC_PN9);

  txmod_pn9 #(.PN_W(PN_W), .PN_TAP(PN_TAP)) u_pn (
    .clk(clk), .rst_n(rst_n), .seed(pn_seed), .adv(pn_adv), .bit_o(pn_bit)
  );

  txmod_bitclk #(.PER_W(PER_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .start(start),
    .bnd_run(bnd_run), .clk_o(ck_raw)
  );

  always_comb begin
    unique case (src_act)
      SRC_GPIO: sel_bit = gpio_in;
      SRC_SDI:  sel_bit = csn_in & sdi_in;
      SRC_FIFO: sel_bit = fifo_bit;
      default:  sel_bit = pn_bit;
    endcase
  end

  assign mod_data   = tx_en & (sel_bit ^ ctl.inv);
  assign mod_type   = ctl.mtype;
  assign fdev_msb   = ctl.fdev_msb;
  assign gpio_clk_o = ck_raw & (ctl.ck == CK_GPIO);
  assign sdo_clk_o  = ck_raw & (ctl.ck == CK_SDO) & csn_in;
  assign irq_clk_o  = ck_raw & (ctl.ck == CK_IRQ);

  AST_SRC_HOLD_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_q && !bit_stb) |=> $stable(src_act)); // R8
  AST_SDI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && (src_act == SRC_SDI) && !csn_in) |-> (mod_data == ctl.inv)); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !(mod_data || gpio_clk_o || sdo_clk_o || irq_clk_o)); // R11
  AST_ONE_CLK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpio_clk_o, sdo_clk_o, irq_clk_o})); // R9

endmodule

// File: tb/txmod_src_sel_test.sv
module txmod_src_sel_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_en = 1'b0, bit_stb = 1'b0;
  logic       gpio_in = 1'b0, sdi_in = 1'b0, csn_in = 1'b1;
  logic [7:0] fifo_data;
  logic       fifo_pop, mod_data, fdev_msb;
  logic [1:0] mod_type;
  logic       gpio_clk_o, sdo_clk_o, irq_clk_o;

  int n_run = 0, n_fail = 0;
  int pops = 0, fbase = 0;
  logic [7:0] fb [4];

  always #4 clk = ~clk;

  always @(posedge clk) if (fifo_pop) pops <= pops + 1;
  assign fifo_data = fb[2'(pops - fbase)];

  txmod_src_sel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_en(tx_en), .bit_stb(bit_stb), .gpio_in(gpio_in), .sdi_in(sdi_in),
    .csn_in(csn_in), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .mod_data(mod_data), .mod_type(mod_type), .fdev_msb(fdev_msb),
    .gpio_clk_o(gpio_clk_o), .sdo_clk_o(sdo_clk_o), .irq_clk_o(irq_clk_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic stb();
    bit_stb = 1'b1; tick(); bit_stb = 1'b0;
  endtask

  task automatic bitgap(input int p);
    tick(p - 1); stb();
  endtask

  task automatic tx_on();  tx_en = 1'b1; tick(); endtask
  task automatic tx_off(); tx_en = 1'b0; tick(); endtask

  task automatic t_reset();
    chk("R1 mtype", 32'(mod_type), 3);
    chk("R1 fdev", 32'(fdev_msb), 0);
    fb[0] = 8'h80; fbase = pops;
    tx_on();
    chk("R1 fifo src", 32'(mod_data), 1);
    chk("R1 pop", 32'(pops - fbase), 1);
    bitgap(8); bitgap(8); tick(5);
    chk("R1 no clock", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 0);
    tx_off();
  endtask

  task automatic t_fields();
    wr(8'h36);
    chk("R2 mtype", 32'(mod_type), 2);
    chk("R2 fdev", 32'(fdev_msb), 1);
  endtask

  task automatic t_gpio();
    logic [4:0] pat = 5'b10110;
    wr(8'h03); tx_on();
    for (int i = 0; i < 5; i++) begin
      gpio_in = pat[i]; #1;
      chk("R3 passthrough", 32'(mod_data), 32'(pat[i]));
    end
    stb(); gpio_in = 1'b1; #1;
    chk("R3 after boundary", 32'(mod_data), 1);
    gpio_in = 1'b0; tx_off();
  endtask

  task automatic t_sdi();
    wr(8'h13); csn_in = 1'b1; tx_on();
    sdi_in = 1'b1; #1; chk("R4 sdi 1", 32'(mod_data), 1);
    sdi_in = 1'b0; #1; chk("R4 sdi 0", 32'(mod_data), 0);
    csn_in = 1'b0; sdi_in = 1'b1; #1; chk("R4 held", 32'(mod_data), 0);
    wr(8'h1B); #1; chk("R4 held inverted", 32'(mod_data), 1);
    csn_in = 1'b1; #1; chk("R7 sdi inverted", 32'(mod_data), 0);
    sdi_in = 1'b0; tx_off();
  endtask

  task automatic t_fifo();
    logic [15:0] w = 16'hA53C;
    wr(8'h23); fb[0] = 8'hA5; fb[1] = 8'h3C; fbase = pops;
    tx_on();
    for (int i = 0; i < 16; i++) begin
      chk("R5 bit", 32'(mod_data), 32'(w[15 - i]));
      if (i == 0 || i == 7) chk("R5 pops", 32'(pops - fbase), 1);
      if (i == 8) chk("R5 pops", 32'(pops - fbase), 2);
      bitgap(8);
    end
    tx_off();
  endtask

  task automatic t_pn9();
    logic o [48];
    for (int n = 0; n < 48; n++) o[n] = (n < 9) ? 1'b1 : (o[n - 9] ^ o[n - 4]);
    wr(8'h33); tx_on();
    for (int n = 0; n < 48; n++) begin
      chk("R6 seq", 32'(mod_data), 32'(o[n]));
      bitgap(4);
    end
    tx_off();
  endtask

  task automatic t_inv();
    wr(8'h0B); tx_on();
    gpio_in = 1'b1; #1; chk("R7 inv 1", 32'(mod_data), 0);
    gpio_in = 1'b0; #1; chk("R7 inv 0", 32'(mod_data), 1);
    tx_off();
  endtask

  task automatic t_switch();
    wr(8'h03); gpio_in = 1'b0; tx_on();
    fb[0] = 8'hC3; fbase = pops;
    wr(8'h23);
    gpio_in = 1'b1; #1; chk("R8 still gpio", 32'(mod_data), 1);
    gpio_in = 1'b0; #1; chk("R8 still gpio", 32'(mod_data), 0);
    chk("R8 no early pop", 32'(pops - fbase), 0);
    stb();
    chk("R8 fifo msb", 32'(mod_data), 1);
    chk("R8 pop at boundary", 32'(pops - fbase), 1);
    gpio_in = 1'b0; bitgap(8);
    chk("R8 fifo bit6", 32'(mod_data), 1);
    bitgap(8);
    chk("R8 fifo bit5", 32'(mod_data), 0);
    tx_off();
  endtask

  task automatic t_clk();
    wr(8'h43); csn_in = 1'b1; tx_on();
    for (int j = 1; j < 8; j++) begin
      tick(); chk("R10 first bit low", 32'(gpio_clk_o), 0);
    end
    stb();
    chk("R10 phase", 32'(gpio_clk_o), 0);
    for (int j = 1; j < 8; j++) begin
      tick(); chk("R10 phase", 32'(gpio_clk_o), 32'(j >= 4));
    end
    stb(); tick(5);
    chk("R9 gpio route", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 3'b100);
    wr(8'hC3);
    chk("R9 irq route", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 3'b001);
    wr(8'h83);
    chk("R9 sdo route", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 3'b010);
    csn_in = 1'b0; #1;
    chk("R9 sdo gated", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 3'b000);
    csn_in = 1'b1; wr(8'h03);
    chk("R9 none", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 3'b000);
    tx_off();
  endtask

  task automatic t_idle();
    wr(8'h43); gpio_in = 1'b1; tx_en = 1'b0; tick(3);
    chk("R11 data", 32'(mod_data), 0);
    chk("R11 clock", {29'd0, gpio_clk_o, sdo_clk_o, irq_clk_o}, 0);
    gpio_in = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    fb[0] = '0; fb[1] = '0; fb[2] = '0; fb[3] = '0;
    tick(3); rst_n = 1'b1; tick();
    t_reset();
    t_fields();
    t_gpio();
    t_sdi();
    t_fifo();
    t_pn9();
    t_inv();
    t_switch();
    t_clk();
    t_idle();
    summary();
  end

endmodule